// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns a fixed reference clock into the SCL waveform of an I2C master. It also produces two strobes that tell the master's bit engine when to act on SDA. The engine asks for one bus phase at a time: a START, a data bit or a STOP. The generator runs that phase and emits a one-cycle done pulse when it completes. A transmit drive strobe marks the point in the SCL low phase where the engine may change SDA. A receive sample strobe marks the point in the SCL high phase where the engine should capture SDA.

Three timing words set the phase lengths and strobe positions. Each word is 2*FW bits wide and holds two FW-bit fields. The hardware adds fixed extra cycles to the programmed low and high counts. After a STOP, a programmable bus-free interval must pass before the lead-in of the next START may begin. A START that arrives earlier is held, not refused. The block does not compute timing values from a bus speed, and it does not support clock stretching by slaves.

Top module: `tg_scl_gen`

## Requirements
- R1: While and after reset: SCL is released (scl_low_o=0), busy_o=0, and no strobe or done pulse is active until a command is accepted.
- R2: Word layout (FW=16 by default). tim_a_i holds the high count in its upper FW bits and the receive offset in its lower FW bits. tim_b_i holds the low count upper and the transmit offset lower. tim_c_i holds the bus-free count upper and the lead-in count lower.
- R3: A bit or STOP first drives SCL low for (low count + 2) cycles. It then releases SCL for (high count + 7) cycles. The first low cycle is the cycle after the command is sampled.
- R4: tx_stb_o pulses for one cycle in the low-phase cycle whose index equals the transmit offset; the first low cycle is index 0. No pulse occurs if the offset is at least (low count + 2).
- R5: During a bit, rx_stb_o pulses for one cycle in the high-phase cycle whose index equals the receive offset. There is no pulse during a STOP, and none if the offset is at least (high count + 7).
- R6: A START is accepted only when idle. SCL stays released for max(lead-in, 1) cycles after the wait for bus-free ends. SCL then goes low in the same cycle that start_done_o pulses.
- R7: After its released phase, a STOP pulses stop_done_o with SCL still released and returns to idle.
- R8: If a START is sampled at cycle E and the last stop_done_o was at cycle S with bus-free count B, start_done_o comes at max(E, S+B) + max(lead-in, 1).
- R9: Command encoding on cmd_op_i: 0 = START, 1 = bit, 2 = STOP, 3 = no operation. These commands are ignored and change no output: a bit or STOP while idle, a START while holding SCL low, any command while busy, and code 3.
- R10: Timing words are taken at command acceptance. Changes to them during a phase do not alter that phase.
- R11: When a bit's high phase ends, bit_done_o pulses in the same cycle that SCL goes low again. No two done pulses are ever active together.
- R12: busy_o is high from the cycle after a command is accepted until the phase ends. It is low in the cycle of the done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tim_a_i | input | 2*FW | High count and receive offset |
| tim_b_i | input | 2*FW | Low count and transmit offset |
| tim_c_i | input | 2*FW | Bus-free count and lead-in count |
| cmd_valid_i | input | 1 | Command request, sampled each cycle |
| cmd_op_i | input | 2 | Command code |
| scl_low_o | output | 1 | 1 drives SCL low; 0 releases it |
| tx_stb_o | output | 1 | SDA change point in the low phase |
| rx_stb_o | output | 1 | SDA sample point in the high phase |
| start_done_o | output | 1 | START phase finished |
| bit_done_o | output | 1 | Bit phase finished |
| stop_done_o | output | 1 | STOP phase finished |
| busy_o | output | 1 | A phase is running |

## Verification
Two functions can fall in the same cycle: the expiry of the bus-free count and the arrival of a new START request. The bench provokes this by placing the START request exactly on the cycle where the bus-free interval runs out. It also places one request before that cycle and one after it. In each case the scoreboard predicts the cycle of the SCL fall and of start_done_o from R8. Any gap of one cycle, early or late, is reported as a mismatch.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HOLD,
    ST_LOW,
    ST_HIGH
  } tg_state_e;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_BIT   = 2'd1;
  localparam logic [1:0] OP_STOP  = 2'd2;

  localparam int LOW_EXTRA  = 2;
  localparam int HIGH_EXTRA = 7;
  localparam int NUM_WORDS  = 3;

endpackage

// File: rtl/tg_fields.sv
module tg_fields #(
  parameter int FW = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [2*FW-1:0]   w_a_i,
  input  logic [2*FW-1:0]   w_b_i,
  input  logic [2*FW-1:0]   w_c_i,
  output logic [FW:0]       hi_last_o,
  output logic [FW:0]       lo_last_o,
  output logic [FW-1:0]     rx_off_o,
  output logic [FW-1:0]     tx_off_o,
  output logic [FW-1:0]     free_cnt_o,
  output logic [FW-1:0]     lead_last_o
);
  import tg_pkg::*;

  localparam int WW = 2 * FW;
  localparam int CW = FW + 1;

  logic [WW-1:0] raw [NUM_WORDS];
  logic [WW-1:0] eff [NUM_WORDS];

  assign raw[0] = w_a_i;
  assign raw[1] = w_b_i;
  assign raw[2] = w_c_i;

  // Each word is held at acceptance; the accepting cycle sees the fresh value.
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [WW-1:0] held_q;
    always_ff @(posedge clk_i) begin
      if (rst_i)       held_q <= '0;
      else if (load_i) held_q <= raw[g];
    end
    assign eff[g] = load_i ? raw[g] : held_q;
  end

  logic [FW-1:0] hi_cnt, lo_cnt, lead_cnt;

  assign hi_cnt     = eff[0][WW-1:FW];
  assign rx_off_o   = eff[0][FW-1:0];
  assign lo_cnt     = eff[1][WW-1:FW];
  assign tx_off_o   = eff[1][FW-1:0];
  assign free_cnt_o = eff[2][WW-1:FW];
  assign lead_cnt   = eff[2][FW-1:0];

  assign hi_last_o   = {1'b0, hi_cnt} + CW'(HIGH_EXTRA - 1);
  assign lo_last_o   = {1'b0, lo_cnt} + CW'(LOW_EXTRA - 1);
  assign lead_last_o = (lead_cnt == '0) ? '0 : lead_cnt - FW'(1);

endmodule

// File: rtl/tg_free_ctr.sv
module tg_free_ctr #(
  parameter int FW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          load_i,
  input  logic [FW-1:0] value_i,
  output logic          free_o
);

  logic [FW-1:0] fc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)              fc_q <= '0;
    else if (load_i)        fc_q <= value_i;
    else if (fc_q != '0)    fc_q <= fc_q - FW'(1);
  end

  assign free_o = (fc_q == '0);

  // R8: the interval shrinks by exactly one each cycle until it expires
  a_r8_count_down: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && fc_q != '0) |=> (fc_q == $past(fc_q) - FW'(1)));

  // R8: a load restarts the interval with the programmed count
  a_r8_reload: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (fc_q == $past(value_i)));

endmodule

// File: rtl/tg_scl_gen.sv
module tg_scl_gen #(
  parameter int FW = 16
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [2*FW-1:0] tim_a_i,
  input  logic [2*FW-1:0] tim_b_i,
  input  logic [2*FW-1:0] tim_c_i,
  input  logic            cmd_valid_i,
  input  logic [1:0]      cmd_op_i,
  output logic            scl_low_o,
  output logic            tx_stb_o,
  output logic            rx_stb_o,
  output logic            start_done_o,
  output logic            bit_done_o,
  output logic            stop_done_o,
  output logic            busy_o
);
  import tg_pkg::*;

  localparam int CW = FW + 1;

  tg_state_e     state_q, nxt_state;
  logic [CW-1:0] cnt_q, nxt_cnt;
  logic          stop_q, nxt_stop;
  logic          accept, free_load, bus_free;
  logic          d_start, d_bit, d_stop;

  logic [CW-1:0] hi_last, lo_last;
  logic [FW-1:0] rx_off, tx_off, free_cnt, lead_last;

  tg_fields #(.FW(FW)) u_fields (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .load_i      (accept),
    .w_a_i       (tim_a_i),
    .w_b_i       (tim_b_i),
    .w_c_i       (tim_c_i),
    .hi_last_o   (hi_last),
    .lo_last_o   (lo_last),
    .rx_off_o    (rx_off),
    .tx_off_o    (tx_off),
    .free_cnt_o  (free_cnt),
    .lead_last_o (lead_last)
  );

  tg_free_ctr #(.FW(FW)) u_free (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (free_load),
    .value_i (free_cnt),
    .free_o  (bus_free)
  );

  always_comb begin
    nxt_state = state_q;
    nxt_cnt   = cnt_q;
    nxt_stop  = stop_q;
    accept    = 1'b0;
    free_load = 1'b0;
    d_start   = 1'b0;
    d_bit     = 1'b0;
    d_stop    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid_i && cmd_op_i == OP_START) begin
          accept    = 1'b1;
          nxt_state = ST_LEAD;
          nxt_cnt   = '0;
        end
      end
      ST_LEAD: begin
        // lead-in counting is frozen until the bus-free interval expires
        if (bus_free) begin
          if (cnt_q >= {1'b0, lead_last}) begin
            nxt_state = ST_HOLD;
            nxt_cnt   = '0;
            d_start   = 1'b1;
          end else begin
            nxt_cnt = cnt_q + CW'(1);
          end
        end
      end
      ST_HOLD: begin
        if (cmd_valid_i && (cmd_op_i == OP_BIT || cmd_op_i == OP_STOP)) begin
          accept    = 1'b1;
          nxt_state = ST_LOW;
          nxt_cnt   = '0;
          nxt_stop  = (cmd_op_i == OP_STOP);
        end
      end
      ST_LOW: begin
        if (cnt_q == lo_last) begin
          nxt_state = ST_HIGH;
          nxt_cnt   = '0;
        end else begin
          nxt_cnt = cnt_q + CW'(1);
        end
      end
      ST_HIGH: begin
        if (cnt_q == hi_last) begin
          nxt_cnt = '0;
          if (stop_q) begin
            nxt_state = ST_IDLE;
            d_stop    = 1'b1;
            free_load = 1'b1;
          end else begin
            nxt_state = ST_HOLD;
            d_bit     = 1'b1;
          end
        end else begin
          nxt_cnt = cnt_q + CW'(1);
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  // Outputs are registered from the next state so they line up with state_q.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      stop_q       <= 1'b0;
      scl_low_o    <= 1'b0;
      tx_stb_o     <= 1'b0;
      rx_stb_o     <= 1'b0;
      start_done_o <= 1'b0;
      bit_done_o   <= 1'b0;
      stop_done_o  <= 1'b0;
      busy_o       <= 1'b0;
    end else begin
      state_q      <= nxt_state;
      cnt_q        <= nxt_cnt;
      stop_q       <= nxt_stop;
      scl_low_o    <= (nxt_state == ST_HOLD) || (nxt_state == ST_LOW);
      tx_stb_o     <= (nxt_state == ST_LOW) && (nxt_cnt == {1'b0, tx_off});
      rx_stb_o     <= (nxt_state == ST_HIGH) && !nxt_stop &&
                      (nxt_cnt == {1'b0, rx_off});
      start_done_o <= d_start;
      bit_done_o   <= d_bit;
      stop_done_o  <= d_stop;
      busy_o       <= (nxt_state == ST_LEAD) || (nxt_state == ST_LOW) ||
                      (nxt_state == ST_HIGH);
    end
  end

  // R5: sampling happens only while SCL is released
  a_r5_rx_released: assert property (@(posedge clk_i) disable iff (rst_i)
    rx_stb_o |-> !scl_low_o);

  // R4: SDA changes only while SCL is held low
  a_r4_tx_low: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_stb_o |-> scl_low_o);

  // R11: done pulses never overlap
  a_r11_one_done: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({start_done_o, bit_done_o, stop_done_o}));

  // R6: start completion coincides with SCL falling
  a_r6_start_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    start_done_o |-> (scl_low_o && !$past(scl_low_o)));

  // R7: stop ends with SCL released and the block idle
  a_r7_stop_released: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_done_o |-> (!scl_low_o && !busy_o));

  // R8: a START never completes while the bus-free interval is running
  a_r8_free_first: assert property (@(posedge clk_i) disable iff (rst_i)
    start_done_o |-> $past(bus_free));

  // R9: a non-START command while idle leaves the block idle
  a_r9_idle_ignore: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_IDLE && cmd_valid_i && cmd_op_i != OP_START) |=> !busy_o);

  // R12: busy is low in the cycle of a bit completion
  a_r12_busy_done: assert property (@(posedge clk_i) disable iff (rst_i)
    bit_done_o |-> !busy_o);

endmodule

// File: tb/sim_tg_scl_gen.sv
`timescale 1ns/1ps
module sim_tg_scl_gen;

  localparam int FW = 16;
  localparam int K_FALL = 0, K_RISE = 1, K_TX = 2, K_RX = 3,
                 K_START = 4, K_BIT = 5, K_STOP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*FW-1:0] ta = '0, tb = '0, tc = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic scl_low, tx_stb, rx_stb, sdone, bdone, pdone, busy;

  always #10 clk = ~clk;

  tg_scl_gen #(.FW(FW)) u0 (
    .clk_i(clk), .rst_i(rst), .tim_a_i(ta), .tim_b_i(tb), .tim_c_i(tc),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .scl_low_o(scl_low), .tx_stb_o(tx_stb), .rx_stb_o(rx_stb),
    .start_done_o(sdone), .bit_done_o(bdone), .stop_done_o(pdone),
    .busy_o(busy)
  );

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic scl_prev = 1'b0;
  int stop_at = -100000;
  int stop_bf = 0;

  int    q_cyc[$];
  int    q_kind[$];
  string q_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int c, input int k, input string req);
    q_cyc.push_back(c);
    q_kind.push_back(k);
    q_req.push_back(req);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares observed events against the scoreboard queue.
  always @(negedge clk) begin
    logic [6:0] ev;
    if (mon_on) begin
      ev[K_FALL]  = scl_low && !scl_prev;
      ev[K_RISE]  = !scl_low && scl_prev;
      ev[K_TX]    = tx_stb;
      ev[K_RX]    = rx_stb;
      ev[K_START] = sdone;
      ev[K_BIT]   = bdone;
      ev[K_STOP]  = pdone;
      for (int k = 0; k < 7; k++) begin
        if (ev[k]) begin
          n_checks++;
          if (q_cyc.size() != 0 && q_cyc[0] == cyc && q_kind[0] == k) begin
            void'(q_cyc.pop_front());
            void'(q_kind.pop_front());
            void'(q_req.pop_front());
          end else begin
            n_fail++;
            if (q_cyc.size() != 0)
              $display("FAIL %s event: actual kind %0d at cycle %0d expected kind %0d at cycle %0d",
                       q_req[0], k, cyc, q_kind[0], q_cyc[0]);
            else
              $display("FAIL R9 event: actual kind %0d at cycle %0d expected none", k, cyc);
          end
        end
      end
      while (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
        n_checks++;
        n_fail++;
        $display("FAIL %s missing event: actual none at cycle %0d expected kind %0d at cycle %0d",
                 q_req[0], cyc, q_kind[0], q_cyc[0]);
        void'(q_cyc.pop_front());
        void'(q_kind.pop_front());
        void'(q_req.pop_front());
      end
    end
    scl_prev = scl_low;
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // START: fall and start_done at max(accept, stop+bf) + max(lead,1)
  task automatic do_start(input int lead, input int at, input string req);
    int c0, f, d;
    @(negedge clk);
    while (cyc + 1 < at) @(negedge clk);
    c0 = cyc + 1;
    f = (c0 > stop_at + stop_bf) ? c0 : stop_at + stop_bf;
    d = f + ((lead == 0) ? 1 : lead);
    tc = {tc[2*FW-1:FW], FW'(lead)};
    push(d, K_FALL, "R6");
    push(d, K_START, req);
    cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
    check(busy == 1'b1, "R12", "busy after START accept", busy, 1);
    wait_until(d);
    check(busy == 1'b0, "R12", "busy at start_done", busy, 0);
  endtask

  // Bit: low phase lo+2, high phase hi+7, strobes at offsets
  task automatic do_bit(input int hi, input int rx, input int lo, input int tx,
                        input bit disturb);
    int c0, l, h;
    @(negedge clk);
    ta = {FW'(hi), FW'(rx)};
    tb = {FW'(lo), FW'(tx)};
    l = lo + 2; h = hi + 7;
    c0 = cyc + 1;
    if (tx < l) push(c0 + tx, K_TX, "R4");
    push(c0 + l, K_RISE, "R3");
    if (rx < h) push(c0 + l + rx, K_RX, "R5");
    push(c0 + l + h, K_FALL, "R3");
    push(c0 + l + h, K_BIT, "R11");
    cmd_valid = 1'b1; cmd_op = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
    check(busy == 1'b1, "R12", "busy during bit", busy, 1);
    if (disturb) begin
      // R10: new words mid-phase; R9: STOP while busy
      ta = {FW'(30), FW'(0)};
      tb = {FW'(40), FW'(0)};
      cmd_valid = 1'b1; cmd_op = 2'd2;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'd3;
    end
    wait_until(c0 + l + h);
    check(busy == 1'b0, "R12", "busy at bit_done", busy, 0);
    check(scl_low == 1'b1, "R11", "SCL low after bit", scl_low, 1);
  endtask

  task automatic do_stop(input int hi, input int rx, input int lo, input int tx,
                         input int bf);
    int c0, l, h;
    @(negedge clk);
    ta = {FW'(hi), FW'(rx)};
    tb = {FW'(lo), FW'(tx)};
    tc = {FW'(bf), tc[FW-1:0]};
    l = lo + 2; h = hi + 7;
    c0 = cyc + 1;
    if (tx < l) push(c0 + tx, K_TX, "R4");
    push(c0 + l, K_RISE, "R7");
    push(c0 + l + h, K_STOP, "R7");
    cmd_valid = 1'b1; cmd_op = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
    wait_until(c0 + l + h);
    stop_at = c0 + l + h;
    stop_bf = bf;
    check(scl_low == 1'b0, "R7", "SCL released at stop_done", scl_low, 0);
    check(busy == 1'b0, "R7", "idle after stop", busy, 0);
  endtask

  task automatic do_ignored(input logic [1:0] op, input logic exp_scl);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9", "busy after ignored command", busy, 0);
    check(scl_low == exp_scl, "R9", "SCL after ignored command", scl_low, exp_scl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(scl_low == 1'b0 && busy == 1'b0, "R1", "outputs in reset", scl_low, 0);
    rst = 1'b0;
    @(negedge clk);
    check(scl_low == 1'b0, "R1", "SCL after reset", scl_low, 0);
    check({tx_stb, rx_stb, sdone, bdone, pdone, busy} == 6'b0, "R1",
          "strobes after reset", {tx_stb, rx_stb, sdone, bdone, pdone, busy}, 0);
    scl_prev = scl_low;
    mon_on = 1'b1;

    do_ignored(2'd1, 1'b0);                 // R9 bit while idle
    do_ignored(2'd3, 1'b0);                 // R9 no-op code
    do_start(4, 0, "R6");                   // R6 plain START
    do_ignored(2'd0, 1'b1);                 // R9 START while holding
    do_bit(2, 3, 3, 1, 1'b0);               // R3 R4 R5 basic bit
    do_bit(20, 5, 10, 7, 1'b0);             // R2 distinct field values
    do_bit(2, 0, 3, 0, 1'b0);               // R4 R5 offset zero
    do_bit(2, 8, 3, 4, 1'b0);               // R4 R5 last-cycle offsets
    do_bit(2, 9, 3, 5, 1'b0);               // R4 R5 offsets out of range
    do_bit(2, 3, 3, 1, 1'b1);               // R10 and R9 while busy
    do_stop(2, 0, 3, 2, 5);                 // R7 stop, no rx strobe
    do_start(0, 0, "R8");                   // R8 early request, lead 0
    do_bit(1, 2, 1, 1, 1'b0);
    do_stop(1, 1, 1, 1, 6);
    do_start(3, stop_at + 6, "R8");         // R8 request on the expiry cycle
    do_stop(1, 1, 1, 1, 4);
    do_start(2, stop_at + 6, "R8");         // R8 request after expiry

    repeat (4) @(negedge clk);
    check(q_cyc.size() == 0, "R11", "scoreboard drained", q_cyc.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule